// File: doc/BRIEF.md
# Debug Memory-Read Instruction Sequencer

This block sits inside a debug module. It reads one 32-bit word of memory for a debugger without a bus master of its own. It does this by handing the CPU a short, fixed program, one instruction at a time. When a request with a target address arrives, the sequencer builds the 32-bit address in scratch register x1 with a `lui`/`addi` pair. It then loads the word at that address back into x1. Last, it issues a `csrrw` that writes x1 to the debug data CSR at address 0x7B4.

The CPU returns the written value through a mailbox push, which carries a valid bit and the data. The sequencer takes that push and presents it to the JTAG-side logic as a one-cycle response. A busy flag covers the whole operation, from the accepted request to the response. While busy is high, further requests are ignored. Pushes that arrive before the final instruction has been handed over are also ignored, and so are pushes that arrive while the block is idle.

Top module: `dbg_memrd_seq`

## Requirements
- R1: After reset, `busy`, `insn_valid` and `rsp_valid` are all low.
- R2: A request (`req_valid` high while `busy` is low) is taken at a clock edge. From the next cycle, `busy` is high and `insn_valid` is high with the first instruction.
- R3: The first instruction is `lui x1` with the encoding {U, 5'd1, 7'b0110111}. U is the address's bits 31:12 plus the value of address bit 11, modulo 2^20.
- R4: The second instruction is `addi x1, x1` with the encoding {addr[11:0], 5'd1, 3'b000, 5'd1, 7'b0010011}.
- R5: The third instruction is `lw x1, 0(x1)` with the encoding {12'd0, 5'd1, 3'b010, 5'd1, 7'b0000011}.
- R6: The fourth instruction is `csrrw x0, 0x7B4, x1` with the encoding {12'h7B4, 5'd1, 3'b001, 5'd0, 7'b1110011}.
- R7: Each instruction stays on `insn_data` with `insn_valid` high and its value unchanged until a cycle in which `insn_ready` is high. The next instruction appears in the following cycle. After the fourth instruction is taken, `insn_valid` goes low.
- R8: A request made while `busy` is high has no effect. The address of the operation already under way is still used for every instruction.
- R9: A mailbox push is ignored, and produces no response, in these cases: while idle, or before the fourth instruction has been taken.
- R10: A push received after the fourth instruction has been taken causes `rsp_valid` to be high for exactly one cycle, in the next cycle, with `rsp_data` equal to the pushed data. In that same cycle, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Word address to read |
| busy | output | 1 | Operation in progress |
| insn_valid | output | 1 | Instruction offered to the CPU |
| insn_data | output | 32 | Instruction encoding |
| insn_ready | input | 1 | CPU takes the offered instruction |
| push_valid | input | 1 | CPU wrote the mailbox CSR |
| push_data | input | 32 | Value written to the mailbox CSR |
| rsp_valid | output | 1 | Read result strobe, one cycle |
| rsp_data | output | 32 | Read result |

## Verification
The assertions assume the CPU side behaves reasonably. It may hold `insn_ready` high or low for any number of cycles. It raises `push_valid` only as a single-cycle pulse. The data on the instruction port is expected to change only when the sequencer itself advances.

The stimulus drives every input on the falling edge. Each push is one cycle wide. Stray requests and pushes are placed only at the points that R8 and R9 name. The results are read back through the instruction and response ports that a real debugger would see.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HI   = 3'd1,
    ST_LO   = 3'd2,
    ST_LOAD = 3'd3,
    ST_XFER = 3'd4,
    ST_WAIT = 3'd5
  } step_e;

  localparam logic [6:0] OP_LUI    = 7'b0110111;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_SYSTEM = 7'b1110011;
  localparam logic [2:0] F3_ADDI   = 3'b000;
  localparam logic [2:0] F3_LW     = 3'b010;
  localparam logic [2:0] F3_CSRRW  = 3'b001;

  // Upper immediate, rounded so that the sign-extended low part lands right.
  function automatic logic [19:0] hi_part(input logic [31:0] a);
    return a[31:12] + {19'd0, a[11]};
  endfunction

  function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rd, op};
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

endpackage

// File: rtl/dbgrd_step_ctrl.sv
module dbgrd_step_ctrl
  import dbgrd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_addr,
  input  logic            insn_ready,
  input  logic            push_valid,
  output step_e           step,
  output logic [XLEN-1:0] addr_q,
  output logic            busy,
  output logic            insn_valid,
  output logic            req_take,
  output logic            step_fire,
  output logic            push_take
);

  step_e step_q, step_d;

  assign busy       = (step_q != ST_IDLE);
  assign insn_valid = (step_q == ST_HI) || (step_q == ST_LO) ||
                      (step_q == ST_LOAD) || (step_q == ST_XFER);
  assign req_take   = req_valid && !busy;
  assign step_fire  = insn_valid && insn_ready;
  assign push_take  = (step_q == ST_WAIT) && push_valid;
  assign step       = step_q;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE: if (req_take)  step_d = ST_HI;
      ST_HI:   if (step_fire) step_d = ST_LO;
      ST_LO:   if (step_fire) step_d = ST_LOAD;
      ST_LOAD: if (step_fire) step_d = ST_XFER;
      ST_XFER: if (step_fire) step_d = ST_WAIT;
      ST_WAIT: if (push_take) step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      addr_q <= '0;
    end else begin
      step_q <= step_d;
      if (req_take) addr_q <= req_addr;
    end
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (addr_q == $past(addr_q)) || !$past(busy)); // R8
  AST_HI_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_HI && step_fire) |=> (step_q == ST_LO)); // R7
  AST_XFER_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_XFER && step_fire) |=> (step_q == ST_WAIT) && !insn_valid); // R7
  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> busy && insn_valid); // R2

endmodule

// File: rtl/dbgrd_insn_gen.sv
module dbgrd_insn_gen
  import dbgrd_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          SCRATCH  = 1,
  parameter logic [11:0] CSR_ADDR = 12'h7B4
) (
  input  step_e           step,
  input  logic [XLEN-1:0] addr,
  output logic [31:0]     insn
);

  localparam logic [4:0] RX   = 5'(SCRATCH);
  localparam logic [4:0] R0   = 5'd0;
  localparam logic [11:0] Z12 = 12'd0;

  logic [31:0] w_hi, w_lo, w_ld, w_xf;

  assign w_hi = enc_u(hi_part(addr), RX, OP_LUI);
  assign w_lo = enc_i(addr[11:0], RX, F3_ADDI, RX, OP_IMM);
  assign w_ld = enc_i(Z12, RX, F3_LW, RX, OP_LOAD);
  assign w_xf = enc_i(CSR_ADDR, RX, F3_CSRRW, R0, OP_SYSTEM);

  always_comb begin
    unique case (step)
      ST_HI:   insn = w_hi;
      ST_LO:   insn = w_lo;
      ST_LOAD: insn = w_ld;
      ST_XFER: insn = w_xf;
      default: insn = '0;
    endcase
  end

endmodule

// File: rtl/dbgrd_rsp_capture.sv
module dbgrd_rsp_capture #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_take,
  input  logic [XLEN-1:0] push_data,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= push_take;
      if (push_take) rsp_data <= push_data;
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_RSP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    push_take |=> rsp_valid && (rsp_data == $past(push_data))); // R10

endmodule

// File: rtl/dbg_memrd_seq.sv
module dbg_memrd_seq
  import dbgrd_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          SCRATCH  = 1,
  parameter logic [11:0] CSR_ADDR = 12'h7B4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        busy,
  output logic        insn_valid,
  output logic [31:0] insn_data,
  input  logic        insn_ready,
  input  logic        push_valid,
  input  logic [31:0] push_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);

  step_e           step;
  logic [XLEN-1:0] addr_q;
  logic            req_take;
  logic            step_fire;
  logic            push_take;

  dbgrd_step_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .insn_ready(insn_ready), .push_valid(push_valid), .step(step),
    .addr_q(addr_q), .busy(busy), .insn_valid(insn_valid),
    .req_take(req_take), .step_fire(step_fire), .push_take(push_take)
  );

  dbgrd_insn_gen #(.XLEN(XLEN), .SCRATCH(SCRATCH), .CSR_ADDR(CSR_ADDR)) u_gen (
    .step(step), .addr(addr_q), .insn(insn_data)
  );

  dbgrd_rsp_capture #(.XLEN(XLEN)) u_rsp (
    .clk(clk), .rst_n(rst_n), .push_take(push_take), .push_data(push_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  AST_INSN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !insn_ready) |=> insn_valid && $stable(insn_data)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !insn_valid); // R1
  AST_STRAY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && (insn_valid || !busy)) |=> !rsp_valid); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy); // R10

endmodule

// File: tb/test_dbg_memrd_seq.sv
module test_dbg_memrd_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        busy, insn_valid, rsp_valid;
  logic [31:0] insn_data, rsp_data;
  logic        insn_ready = 1'b0;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dbg_memrd_seq i_dbg_memrd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .insn_valid(insn_valid), .insn_data(insn_data),
    .insn_ready(insn_ready), .push_valid(push_valid), .push_data(push_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected encodings, written from the requirement text.
  function automatic logic [31:0] exp_lui(input logic [31:0] a);
    logic [31:0] rounded;
    rounded = a + 32'h0000_0800;
    return (rounded & 32'hFFFF_F000) | (32'd1 << 7) | 32'h37;
  endfunction
  function automatic logic [31:0] exp_addi(input logic [31:0] a);
    return ((a & 32'hFFF) << 20) | (32'd1 << 15) | (32'd1 << 7) | 32'h13;
  endfunction
  localparam logic [31:0] EXP_LW   = (32'd1 << 15) | (32'd2 << 12) | (32'd1 << 7) | 32'h03;
  localparam logic [31:0] EXP_CSRW = (32'h7B4 << 20) | (32'd1 << 15) | (32'd1 << 12) | 32'h73;

  task automatic step_clk();
    @(negedge clk);
  endtask

  task automatic start(input logic [31:0] a);
    req_addr = a; req_valid = 1'b1;
    step_clk();
    req_valid = 1'b0;
    check("R2 busy", {31'd0, busy}, 32'd1);
    check("R2 insn_valid", {31'd0, insn_valid}, 32'd1);
  endtask

  task automatic take(input string req, input logic [31:0] exp, input int stall);
    for (int s = 0; s < stall; s++) begin
      step_clk();
      check({req, " R7 hold"}, {31'd0, insn_valid}, 32'd1);
      check({req, " R7 stable"}, insn_data, exp);
    end
    check(req, insn_data, exp);
    insn_ready = 1'b1;
    step_clk();
    insn_ready = 1'b0;
  endtask

  task automatic finish_push(input logic [31:0] d);
    check("R7 valid low after last", {31'd0, insn_valid}, 32'd0);
    push_data = d; push_valid = 1'b1;
    step_clk();
    push_valid = 1'b0;
    check("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check("R10 rsp_data", rsp_data, d);
    check("R10 busy low", {31'd0, busy}, 32'd0);
    step_clk();
    check("R10 one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 insn_valid", {31'd0, insn_valid}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_read(input logic [31:0] a, input logic [31:0] d, input int stall);
    start(a);
    take("R3 lui", exp_lui(a), stall);
    take("R4 addi", exp_addi(a), stall);
    take("R5 lw", EXP_LW, stall);
    take("R6 csrw", EXP_CSRW, stall);
    finish_push(d);
  endtask

  task automatic t_busy_req();
    logic [31:0] a = 32'h1357_9ABC;
    start(a);
    req_addr = 32'hFFFF_F7FF; req_valid = 1'b1;
    step_clk();
    req_valid = 1'b0;
    take("R8 lui keeps addr", exp_lui(a), 0);
    take("R8 addi keeps addr", exp_addi(a), 0);
    take("R5 lw", EXP_LW, 0);
    take("R6 csrw", EXP_CSRW, 0);
    finish_push(32'h0BAD_F00D);
  endtask

  task automatic t_stray_push();
    logic [31:0] a = 32'h0000_0FFC;
    push_data = 32'hDEAD_0001; push_valid = 1'b1;
    step_clk();
    push_valid = 1'b0;
    step_clk();
    check("R9 idle push", {31'd0, rsp_valid}, 32'd0);
    start(a);
    take("R3 lui", exp_lui(a), 0);
    push_data = 32'hDEAD_0002; push_valid = 1'b1;
    step_clk();
    push_valid = 1'b0;
    check("R9 early push", {31'd0, rsp_valid}, 32'd0);
    check("R9 still busy", {31'd0, busy}, 32'd1);
    take("R4 addi", exp_addi(a), 0);
    take("R5 lw", EXP_LW, 0);
    take("R6 csrw", EXP_CSRW, 0);
    finish_push(32'h1234_5678);
  endtask

  initial begin
    repeat (3) step_clk();
    rst_n = 1'b1;
    step_clk();
    t_reset();
    t_read(32'h1234_5678, 32'hCAFE_BABE, 0);
    t_read(32'h8000_0800, 32'h0000_0001, 2);
    t_read(32'hFFFF_F800, 32'hFFFF_FFFF, 1);
    t_read(32'h0000_07FC, 32'h5A5A_A5A5, 3);
    t_busy_req();
    t_stray_push();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule